// File: doc/BRIEF.md
# I2C real-time-clock register file

This block is the serial front end of a timekeeping macro. It acts as a 2-wire bus slave with one fixed device address and holds a 64-byte register space. Bytes 0 to 7 carry the clock and control values: seconds, minutes, century/hours, day, date, month, years and control, at offsets 0 through 7. Bytes 8 to 63 are general-purpose storage. A byte pointer selects the location for bus accesses. The first data byte of a write transfer loads the pointer. Every stored or returned byte advances it by one, and it wraps from 63 back to 0.

SCL and SDA arrive asynchronously. Each passes through a two-flop synchronizer, and the bus edges and control conditions are decoded on the system clock. The slave drives SDA only as an open-drain enable: drive low, or release.

A parallel side port lets the timekeeping core write the eight clock registers directly. A power-good input shuts the bus side off whenever the supply is out of tolerance. While it is low, the transfer in progress is dropped, the pointer returns to 0, and nothing on the bus is acknowledged or stored until power-good returns.

Top module: `i2c_rtc_regfile`

## Requirements
- R1: After reset, `sda_oe_o` is 0, the pointer is 0 and every register byte reads as 0x00.
- R2: The slave acknowledges, by driving SDA low on the 9th clock, only the address bytes 0xD0 (write) and 0xD1 (read). After any other address byte it gives no acknowledge for the rest of that transfer and stores nothing.
- R3: In a write transfer, the first data byte sets the pointer from its low 6 bits and the upper 2 bits are ignored. Each later byte is stored at the pointer, which then increments. Every data byte is acknowledged.
- R4: A read transfer returns bytes MSB first, starting at the current pointer and incrementing after each byte. A master ACK (SDA low on the 9th clock) requests the next byte. A master NACK ends the output, and SDA stays released (reads as 0xFF) until the next START.
- R5: The pointer wraps from 63 to 0 for both writes and reads.
- R6: A STOP (SDA rising while SCL is high) returns the slave to idle and leaves the pointer unchanged.
- R7: A START (SDA falling while SCL is high) is accepted in any state, including in the middle of a byte. A partial byte cut short by a START is discarded.
- R8: While `pwr_ok_i` is 0, the transfer in progress is aborted, the pointer is held at 0, and no acknowledge is driven and no byte stored, even for a fresh START. Normal operation resumes after `pwr_ok_i` returns to 1.
- R9: A side-port write with `tk_we_i` high stores `tk_data_i` into clock register `tk_addr_i` (0 to 7) on that clock edge. It is visible to later bus reads, and a bus write to the same byte in the same cycle takes priority.
- R10: The slave changes `sda_oe_o` only after a detected SCL falling edge, a control condition or a power-good drop, never while SCL stays high. Rising SCL, falling SCL, START and STOP are decoded as mutually exclusive events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_ok_i | input | 1 | Supply in tolerance; 0 locks out the bus |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| tk_we_i | input | 1 | Side-port write strobe from the timekeeping core |
| tk_addr_i | input | 3 | Side-port clock register index |
| tk_data_i | input | 8 | Side-port write data |

## Verification
The hardest situation to reach from the ports is a power-good drop that lands inside a byte. The slave has already counted some bits, holds a loaded pointer, and has a store pending. The bench sets the pointer and stores a byte. It then clocks out half of the next byte and pulls `pwr_ok_i` low between two SCL pulses. It keeps bit-banging the remaining bits, a fresh START and more bytes, expecting no acknowledge throughout. After restoring power, it reads from address 0 and from the target address to prove the pointer was cleared and nothing was written. A repeated START issued three bits into a data byte covers the matching abort path for control conditions.

// File: rtl/i2c_rtc_pkg.sv
package i2c_rtc_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_HOLD
  } bus_state_e;
endpackage

// File: rtl/i2c_rtc_sync.sv
module i2c_rtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic cur_o,
  output logic prev_o
);
  // STAGES flops for metastability, one more for edge history
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign cur_o  = pipe_q[STAGES-1];
  assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/i2c_rtc_cond.sv
module i2c_rtc_cond (
  input  logic en_i,
  input  logic scl_cur_i,
  input  logic scl_prev_i,
  input  logic sda_cur_i,
  input  logic sda_prev_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_hold;

  assign scl_hold   = scl_cur_i & scl_prev_i;
  assign scl_rise_o = en_i & scl_cur_i & ~scl_prev_i;
  assign scl_fall_o = en_i & ~scl_cur_i & scl_prev_i;
  assign start_o    = en_i & scl_hold & sda_prev_i & ~sda_cur_i;
  assign stop_o     = en_i & scl_hold & ~sda_prev_i & sda_cur_i;
endmodule

// File: rtl/i2c_rtc_link.sv
module i2c_rtc_link
  import i2c_rtc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         AW       = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [AW-1:0]     ptr_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o
);
  bus_state_e        state_q;
  logic [2:0]        bit_q;
  logic [BYTE_W-1:0] sr_q;
  logic [BYTE_W-1:0] tx_q;
  logic              byte_done_q;
  logic              rw_q;
  logic              first_q;
  logic              ack_q;
  logic              oe_q;
  logic [AW-1:0]     ptr_q;
  logic              rx_phase;

  assign rx_phase  = (state_q == ST_DEV) || (state_q == ST_RX);
  assign wr_en_o   = (state_q == ST_RX) && scl_fall_i && byte_done_q && !first_q;
  assign wr_addr_o = ptr_q;
  assign wr_data_o = sr_q;
  assign ptr_o     = ptr_q;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_q       <= '0;
      sr_q        <= '0;
      tx_q        <= '0;
      byte_done_q <= 1'b0;
      rw_q        <= 1'b0;
      first_q     <= 1'b0;
      ack_q       <= 1'b0;
      oe_q        <= 1'b0;
      ptr_q       <= '0;
    end else if (!en_i) begin
      // power lockout
      state_q     <= ST_IDLE;
      bit_q       <= '0;
      byte_done_q <= 1'b0;
      oe_q        <= 1'b0;
      ptr_q       <= '0;
    end else if (start_i) begin
      state_q     <= ST_DEV;
      bit_q       <= '0;
      byte_done_q <= 1'b0;
      oe_q        <= 1'b0;
    end else if (stop_i) begin
      state_q     <= ST_IDLE;
      byte_done_q <= 1'b0;
      oe_q        <= 1'b0;
    end else begin
      if (rx_phase && scl_rise_i) begin
        sr_q  <= {sr_q[BYTE_W-2:0], sda_i};
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7) byte_done_q <= 1'b1;
      end
      unique case (state_q)
        ST_DEV: begin
          if (scl_fall_i && byte_done_q) begin
            byte_done_q <= 1'b0;
            if (sr_q[7:1] == DEV_ADDR) begin
              rw_q    <= sr_q[0];
              oe_q    <= 1'b1;
              state_q <= ST_DEV_ACK;
            end else begin
              state_q <= ST_HOLD;
            end
          end
        end
        ST_RX: begin
          if (scl_fall_i && byte_done_q) begin
            byte_done_q <= 1'b0;
            if (first_q) begin
              ptr_q   <= sr_q[AW-1:0];
              first_q <= 1'b0;
            end else begin
              ptr_q <= ptr_q + 1'b1;
            end
            oe_q    <= 1'b1;
            state_q <= ST_RX_ACK;
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall_i) begin
            bit_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_data_i;
              oe_q    <= ~rd_data_i[BYTE_W-1];
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              first_q <= 1'b1;
              state_q <= ST_RX;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall_i) begin
            oe_q    <= 1'b0;
            bit_q   <= '0;
            state_q <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (bit_q == 3'd7) begin
              oe_q    <= 1'b0;
              state_q <= ST_TX_ACK;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
              oe_q  <= ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) ack_q <= ~sda_i;
          if (scl_fall_i) begin
            bit_q <= '0;
            if (ack_q) begin
              tx_q    <= rd_data_i;
              oe_q    <= ~rd_data_i[BYTE_W-1];
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_TX;
            end else begin
              state_q <= ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rtc_cells.sv
module i2c_rtc_cells
  import i2c_rtc_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int CLK_REGS = 8,
  localparam int AW      = $clog2(DEPTH),
  localparam int TKW     = $clog2(CLK_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [BYTE_W-1:0] bus_data_i,
  input  logic              tk_we_i,
  input  logic [TKW-1:0]    tk_addr_i,
  input  logic [BYTE_W-1:0] tk_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [BYTE_W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [BYTE_W-1:0] cell_q;
    logic              bus_hit;
    logic              tk_hit;

    assign bus_hit = bus_we_i && (bus_addr_i == AW'(i));
    if (i < CLK_REGS) begin : g_clk
      assign tk_hit = tk_we_i && (tk_addr_i == TKW'(i));
    end else begin : g_ram
      assign tk_hit = 1'b0;
    end

    // bus write wins over side port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cell_q <= '0;
      else if (bus_hit) cell_q <= bus_data_i;
      else if (tk_hit)  cell_q <= tk_data_i;
    end

    assign cells[i] = cell_q;
  end

  assign rd_data_o = cells[rd_addr_i];
endmodule

// File: rtl/i2c_rtc_regfile.sv
module i2c_rtc_regfile
  import i2c_rtc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         DEPTH       = 64,
  parameter int         CLK_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(DEPTH),
  localparam int        TKW         = $clog2(CLK_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              tk_we_i,
  input  logic [TKW-1:0]    tk_addr_i,
  input  logic [BYTE_W-1:0] tk_data_i
);
  logic              scl_cur, scl_prev, sda_cur, sda_prev;
  logic              scl_rise_w, scl_fall_w, start_w, stop_w;
  logic              bus_we_w;
  logic [AW-1:0]     bus_addr_w;
  logic [BYTE_W-1:0] bus_data_w;
  logic [AW-1:0]     ptr_w;
  logic [BYTE_W-1:0] rd_data_w;

  i2c_rtc_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (scl_i),
    .cur_o (scl_cur),
    .prev_o(scl_prev)
  );

  i2c_rtc_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sda_i),
    .cur_o (sda_cur),
    .prev_o(sda_prev)
  );

  i2c_rtc_cond u_cond (
    .en_i      (pwr_ok_i),
    .scl_cur_i (scl_cur),
    .scl_prev_i(scl_prev),
    .sda_cur_i (sda_cur),
    .sda_prev_i(sda_prev),
    .scl_rise_o(scl_rise_w),
    .scl_fall_o(scl_fall_w),
    .start_o   (start_w),
    .stop_o    (stop_w)
  );

  i2c_rtc_link #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (pwr_ok_i),
    .sda_i     (sda_cur),
    .scl_rise_i(scl_rise_w),
    .scl_fall_i(scl_fall_w),
    .start_i   (start_w),
    .stop_i    (stop_w),
    .rd_data_i (rd_data_w),
    .ptr_o     (ptr_w),
    .wr_en_o   (bus_we_w),
    .wr_addr_o (bus_addr_w),
    .wr_data_o (bus_data_w),
    .sda_oe_o  (sda_oe_o)
  );

  i2c_rtc_cells #(.DEPTH(DEPTH), .CLK_REGS(CLK_REGS)) u_cells (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_we_i  (bus_we_w),
    .bus_addr_i(bus_addr_w),
    .bus_data_i(bus_data_w),
    .tk_we_i   (tk_we_i),
    .tk_addr_i (tk_addr_i),
    .tk_data_i (tk_data_i),
    .rd_addr_i (ptr_w),
    .rd_data_o (rd_data_w)
  );
endmodule

// File: rtl/i2c_rtc_chk.sv
module i2c_rtc_chk #(
  parameter int AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pwr_ok_i,
  input logic          sda_oe_o,
  input logic [AW-1:0] ptr_w,
  input logic          bus_we_w,
  input logic          scl_rise_w,
  input logic          scl_fall_w,
  input logic          start_w,
  input logic          stop_w
);
  // R8
  pwr_oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> !sda_oe_o);

  // R8
  pwr_ptr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> (ptr_w == '0));

  // R8
  pwr_no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_w |-> pwr_ok_i);

  // R6
  stop_keeps_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> (ptr_w == $past(ptr_w)));

  // R10
  oe_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> ($past(scl_fall_w) || $past(start_w) || $past(stop_w) || !$past(pwr_ok_i)));

  // R10
  cond_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scl_rise_w, scl_fall_w, start_w, stop_w}));
endmodule

bind i2c_rtc_regfile i2c_rtc_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_i2c_rtc_regfile.sv
`timescale 1ns/1ps
module sim_i2c_rtc_regfile;
  localparam int Q = 8;
  localparam int WD_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_ok = 1'b1;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       tk_we = 1'b0;
  logic [2:0] tk_addr = '0;
  logic [7:0] tk_data = '0;
  logic       sda_oe;
  logic       sda_line;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model
  logic [7:0] ref_mem [64];
  int         ref_ptr;
  bit         ref_first;

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  i2c_rtc_regfile u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .pwr_ok_i (pwr_ok),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .tk_we_i  (tk_we),
    .tk_addr_i(tk_addr),
    .tk_data_i(tk_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison: slave output must hold while SCL stays high (R10)
  logic scl_p = 1'b1, oe_p = 1'b0, pwr_p = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !done && pwr_ok && pwr_p && scl && scl_p) begin
      checks++;
      if (sda_oe != oe_p) begin
        fails++;
        $display("FAIL R10 act=%0h exp=%0h", sda_oe, oe_p);
      end
    end
    scl_p = scl;
    oe_p  = sda_oe;
    pwr_p = pwr_ok;
  end

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    scl = 1'b1;   wq();
    m_sda = 1'b0; wq();
    scl = 1'b0;   wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    scl = 1'b1;   wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) begin
      m_sda = b[i]; wq();
      scl = 1'b1;   wq(); wq();
      scl = 1'b0;   wq();
    end
  endtask

  task automatic ack_slot(output bit acked);
    m_sda = 1'b1; wq();
    scl = 1'b1;   wq();
    acked = !sda_line;
    wq();
    scl = 1'b0;   wq();
  endtask

  task automatic wb(input logic [7:0] b, output bit acked);
    send_bits(b, 7, 0);
    ack_slot(acked);
  endtask

  task automatic rb(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl = 1'b1; wq();
      b[i] = sda_line;
      wq();
      scl = 1'b0;
    end
    wq();
    m_sda = give_ack ? 1'b0 : 1'b1;
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  // address byte with model update
  task automatic dev(input logic [7:0] a, input string req);
    bit ak;
    wb(a, ak);
    chk(req, ak, (a == 8'hD0 || a == 8'hD1));
    ref_first = 1'b1;
  endtask

  // data byte in a write transfer (R3)
  task automatic wdat(input logic [7:0] b, input string req);
    bit ak;
    wb(b, ak);
    chk(req, ak, 1);
    if (ref_first) begin
      ref_ptr = b & 8'h3F;
      ref_first = 1'b0;
    end else begin
      ref_mem[ref_ptr] = b;
      ref_ptr = (ref_ptr + 1) % 64;
    end
  endtask

  task automatic rdat(input bit give_ack, input string req);
    logic [7:0] b;
    rb(give_ack, b);
    chk(req, b, ref_mem[ref_ptr]);
    ref_ptr = (ref_ptr + 1) % 64;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    bus_start();
    dev(8'hD0, "R2");
    wdat(p, "R3");
  endtask

  initial begin
    bit ak;
    logic [7:0] b;
    for (int i = 0; i < 64; i++) ref_mem[i] = 8'h00;
    ref_ptr = 0;
    ref_first = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", sda_oe, 0);

    // R1: first read after reset comes from address 0 and is zero
    bus_start();
    dev(8'hD1, "R2");
    rdat(1'b0, "R1");
    bus_stop();

    // R3: upper pointer bits ignored, sequential stores
    set_ptr(8'hC8);
    wdat(8'h11, "R3");
    wdat(8'h22, "R3");
    wdat(8'h33, "R3");
    bus_stop();

    // R6: pointer survives STOP; R4: sequential read with ACK/NACK
    set_ptr(8'h08);
    bus_stop();
    bus_start();
    dev(8'hD1, "R4");
    rdat(1'b1, "R4");
    rdat(1'b1, "R6");
    rdat(1'b0, "R4");
    // R4: after NACK the line stays released
    rb(1'b0, b);
    chk("R4", b, 8'hFF);
    bus_stop();

    // R2: foreign address ignored, nothing stored
    bus_start();
    dev(8'hA0, "R2");
    wb(8'h55, ak);
    chk("R2", ak, 0);
    bus_stop();
    bus_start();
    dev(8'hD1, "R2");
    rdat(1'b0, "R2");
    bus_stop();

    // R5: wrap on write, R7 repeated START, wrap on read
    set_ptr(8'd62);
    wdat(8'hA1, "R5");
    wdat(8'hA2, "R5");
    wdat(8'hA3, "R5");
    bus_stop();
    set_ptr(8'd62);
    bus_start();
    dev(8'hD1, "R7");
    rdat(1'b1, "R5");
    rdat(1'b1, "R5");
    rdat(1'b0, "R5");
    bus_stop();

    // R7: START three bits into a data byte
    set_ptr(8'h10);
    send_bits(8'hE7, 7, 5);
    bus_start();
    dev(8'hD0, "R7");
    wdat(8'h20, "R7");
    wdat(8'h5A, "R7");
    bus_stop();
    set_ptr(8'h10);
    bus_start();
    dev(8'hD1, "R7");
    rdat(1'b0, "R7");
    bus_stop();
    set_ptr(8'h20);
    bus_start();
    dev(8'hD1, "R7");
    rdat(1'b0, "R7");
    bus_stop();

    // R9: side port updates clock registers
    @(posedge clk); #1;
    tk_we = 1'b1; tk_addr = 3'd3; tk_data = 8'h27;
    @(posedge clk); #1;
    tk_addr = 3'd7; tk_data = 8'h80;
    @(posedge clk); #1;
    tk_we = 1'b0;
    ref_mem[3] = 8'h27;
    ref_mem[7] = 8'h80;
    set_ptr(8'h03);
    bus_start();
    dev(8'hD1, "R9");
    for (int i = 0; i < 4; i++) rdat(1'b1, "R9");
    rdat(1'b0, "R9");
    bus_stop();

    // R8: power drop inside a byte
    set_ptr(8'h30);
    wdat(8'h77, "R8");
    send_bits(8'h99, 7, 4);
    pwr_ok = 1'b0;
    ref_ptr = 0;
    send_bits(8'h99, 3, 0);
    ack_slot(ak);
    chk("R8", ak, 0);
    bus_stop();
    bus_start();
    wb(8'hD0, ak);
    chk("R8", ak, 0);
    wb(8'h44, ak);
    chk("R8", ak, 0);
    bus_stop();
    repeat (4) @(posedge clk); #1;
    pwr_ok = 1'b1;
    repeat (4) @(posedge clk); #1;
    bus_start();
    dev(8'hD1, "R8");
    rdat(1'b0, "R8");
    bus_stop();
    set_ptr(8'h30);
    bus_start();
    dev(8'hD1, "R8");
    rdat(1'b1, "R8");
    rdat(1'b0, "R8");
    bus_stop();

    repeat (20) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule